// File: doc/BRIEF.md
# Two-Output PWM Time Base with Event Actions

This block produces two pulse-width-modulated outputs from one shared time base. The system clock passes through two prescalers in series. The first divides by a power of two and the second divides by one or by an even ratio. Their combined tick drives a 16-bit counter. In count-up mode the counter climbs from zero to a programmable period and then returns to zero. In stop-freeze mode it holds its value.

Each output has its own compare value and its own action field. When the counter reaches zero, the zero event applies one action to the output. When the counter reaches that output's compare value, the compare event applies another. Each action can leave the output alone, drive it low, drive it high or toggle it. If the zero event sets the output and the compare event toggles it, the output is high from the start of each period until its compare point. One-cycle strobes report the zero event and each compare event.

Software writes the configuration through a plain synchronous write port of address, data and enable. This port has no handshake: every write is accepted in the cycle it is presented, so there is no stream and no back-pressure at the edge of the block. The period can be written directly or held in a shadow register that is loaded at the next wrap. The counter can be written at any time to restart or move the cycle.

Top module: `pwm_timebase_aq`

## Requirements
- R1: While reset is active and after it is released, both PWM outputs, all three strobes and the count output are 0, and the counter is stopped.
- R2: The control word at address 0 holds the counter mode in bits [1:0], the coarse divider select c in bits [4:2] and the fine divider select f in bits [7:5]. In count-up mode the counter advances once every (2^c × F) clocks, where F is 1 for f = 0 and 2·f otherwise.
- R3: Counter mode value 1 is count-up. On each tick the counter increments, and when it is at or above the active period it returns to 0. A period P therefore gives P+1 ticks per cycle.
- R4: Any mode value other than 1 is stop-freeze. The counter holds its value, no strobe is raised and both outputs keep their levels.
- R5: The action fields are at address 5 (output A) and address 6 (output B). Bits [1:0] hold the zero action and bits [3:2] hold the compare action, with codes 0 none, 1 low, 2 high and 3 toggle. A zero event applies the zero action and a compare event applies the compare action. Output A uses the compare value at address 2 and output B uses the compare value at address 3.
- R6: Control bit 8 selects period shadowing. When it is 0, a write to address 1 becomes the active period at once. When it is 1, the write is held and copied to the active period on the tick at which the counter wraps to 0.
- R7: A write to address 4 loads the counter and raises no event in that cycle. It also restarts the prescaler, so the next tick comes a full prescale period later.
- R8: The zero strobe is high for exactly the one cycle in which the count output first shows 0 after a tick. The compare strobe of an output is high for the one cycle in which the count first equals that output's compare value after a tick. Each strobe changes in the same cycle as the count and the outputs.
- R9: When a zero event and a compare event for the same output fall on one tick, only the compare action is applied.
- R10: A compare value greater than the period never matches. That output raises no compare strobe and keeps the level set by its zero action.
- R11: Any write to the control word restarts the prescaler, so the first tick after it has full length.
- R12: Writes to address 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| zero_evt | output | 1 | Counter reached zero on a tick |
| cmpa_evt | output | 1 | Counter reached compare A on a tick |
| cmpb_evt | output | 1 | Counter reached compare B on a tick |
| tb_count | output | 16 | Current time-base count |

## Verification
The hardest cases to reach are those where two things happen on the same tick. One is a zero event that falls on a compare event. Another is a period shadow load that must wait for a wrap partway through a period. A third is a counter or control write that lands while the prescaler is partway through its count. The stimulus sets a compare value of 0 with conflicting actions, so the priority rule decides the level on every period. It rewrites the period in the middle of a cycle in both shadow settings and measures the highest count reached in that period and in the next one. It also writes the counter and the control word at known prescaler phases and counts the clocks until the next tick. A behavioural model run beside the design compares every output on every clock.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int CW    = 16;
  localparam int DIVW  = 3;
  localparam int AW    = 3;
  localparam int ACTF  = 4;
  localparam int NOUT  = 2;
  localparam int FINE_MAX   = 2 * ((1 << DIVW) - 1);
  localparam int COARSE_MAX = 1 << ((1 << DIVW) - 1);
  localparam int PCW   = $clog2(FINE_MAX * COARSE_MAX);

  localparam int CTRL_W     = 2 + 2 * DIVW + 1;
  localparam int COARSE_LSB = 2;
  localparam int FINE_LSB   = 2 + DIVW;
  localparam int SHADOW_BIT = 2 + 2 * DIVW;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  localparam logic [1:0] MODE_UP = 2'd1;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_PRD  = 3'd1;
  localparam logic [AW-1:0] A_CMPA = 3'd2;
  localparam logic [AW-1:0] A_CMPB = 3'd3;
  localparam logic [AW-1:0] A_CNT  = 3'd4;
  localparam logic [AW-1:0] A_ACTA = 3'd5;
  localparam logic [AW-1:0] A_ACTB = 3'd6;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SELW = 3,
  parameter int PCW  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [SELW-1:0] coarse_sel,
  input  logic [SELW-1:0] fine_sel,
  output logic            tick
);
  logic [PCW-1:0] pc_q;
  logic [PCW-1:0] limit;
  int             ratio;

  always_comb begin
    ratio = (fine_sel == '0) ? 1 : 2 * int'(fine_sel);
    ratio = ratio << coarse_sel;
    limit = PCW'(ratio - 1);
  end

  assign tick = run && (pc_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                  pc_q <= '0;
    else if (clr || !run || tick) pc_q <= '0;
    else                          pc_q <= pc_q + 1'b1;
  end

  // R2: with a ratio above one, two ticks are never adjacent unless the settings change
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && limit != '0) |=> !tick);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW   = 16,
  parameter int NOUT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_raw,
  input  logic                    cnt_wr,
  input  logic                    prd_wr,
  input  logic [CW-1:0]           wdata,
  input  logic                    shadow_en,
  input  logic [NOUT-1:0][CW-1:0] cmp,
  output logic [CW-1:0]           cnt_q,
  output logic                    zero_ev,
  output logic [NOUT-1:0]         cmp_ev
);
  logic [CW-1:0] prd_act_q, prd_sh_q, nxt;
  logic          tick, wrap;

  assign tick = tick_raw && !cnt_wr;
  assign wrap = (cnt_q >= prd_act_q);
  assign nxt  = wrap ? '0 : cnt_q + 1'b1;
  assign zero_ev = tick && (nxt == '0);

  for (genvar i = 0; i < NOUT; i++) begin : g_cmp
    assign cmp_ev[i] = tick && (nxt == cmp[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= wdata;
    else if (tick)   cnt_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act_q <= '0;
      prd_sh_q  <= '0;
    end else begin
      if (prd_wr) prd_sh_q <= wdata;
      if (prd_wr && !shadow_en)              prd_act_q <= wdata;
      else if (tick && wrap && shadow_en)    prd_act_q <= prd_sh_q;
    end
  end

  // R4: without a tick or a write the count does not move
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_raw && !cnt_wr) |=> $stable(cnt_q));
  // R3: a tick below the period advances the count by one
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
  // R6: with shadowing on, the active period only changes at a wrap
  assert_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !(tick && wrap)) |=> $stable(prd_act_q));
endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_aq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            zero_ev,
  input  logic            cmp_ev,
  input  logic [ACTF-1:0] act,
  output logic            out_q
);
  logic [1:0] sel;
  logic       nxt;

  always_comb begin
    if (cmp_ev)       sel = act[3:2];
    else if (zero_ev) sel = act[1:0];
    else              sel = ACT_NONE;
    unique case (act_e'(sel))
      ACT_LOW:    nxt = 1'b0;
      ACT_HIGH:   nxt = 1'b1;
      ACT_TOGGLE: nxt = !out_q;
      default:    nxt = out_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= nxt;
  end

  // R9: on a coincident tick a compare toggle wins over any zero action
  assert_cmp_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_ev && cmp_ev && act[3:2] == ACT_TOGGLE) |=> (out_q != $past(out_q)));
endmodule

// File: rtl/pwm_timebase_aq.sv
module pwm_timebase_aq
  import pwm_aq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          zero_evt,
  output logic          cmpa_evt,
  output logic          cmpb_evt,
  output logic [CW-1:0] tb_count
);
  logic [CTRL_W-1:0]          ctrl_q;
  logic [NOUT-1:0][CW-1:0]    cmp_q;
  logic [NOUT-1:0][ACTF-1:0]  act_q;
  logic [NOUT-1:0]            cmp_ev, cmp_ev_q, pwm_q;
  logic                       tick_raw, zero_ev, zero_ev_q;
  logic                       ctrl_wr, cnt_wr, prd_wr, run;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign cnt_wr  = wr_en && (wr_addr == A_CNT);
  assign prd_wr  = wr_en && (wr_addr == A_PRD);
  assign run     = (ctrl_q[1:0] == MODE_UP);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam logic [AW-1:0] CMP_ADDR = A_CMPA + AW'(i);
    localparam logic [AW-1:0] ACT_ADDR = A_ACTA + AW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[i] <= '0;
        act_q[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == CMP_ADDR) cmp_q[i] <= wr_data;
        if (wr_addr == ACT_ADDR) act_q[i] <= wr_data[ACTF-1:0];
      end
    end
    pwm_action u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .zero_ev (zero_ev),
      .cmp_ev  (cmp_ev[i]),
      .act     (act_q[i]),
      .out_q   (pwm_q[i])
    );
  end

  pwm_prescaler #(.SELW(DIVW), .PCW(PCW)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .clr        (ctrl_wr || cnt_wr),
    .coarse_sel (ctrl_q[COARSE_LSB +: DIVW]),
    .fine_sel   (ctrl_q[FINE_LSB +: DIVW]),
    .tick       (tick_raw)
  );

  pwm_counter #(.CW(CW), .NOUT(NOUT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_raw  (tick_raw),
    .cnt_wr    (cnt_wr),
    .prd_wr    (prd_wr),
    .wdata     (wr_data),
    .shadow_en (ctrl_q[SHADOW_BIT]),
    .cmp       (cmp_q),
    .cnt_q     (tb_count),
    .zero_ev   (zero_ev),
    .cmp_ev    (cmp_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_ev_q <= 1'b0;
      cmp_ev_q  <= '0;
    end else begin
      zero_ev_q <= zero_ev;
      cmp_ev_q  <= cmp_ev;
    end
  end

  assign pwm_a    = pwm_q[0];
  assign pwm_b    = pwm_q[1];
  assign zero_evt = zero_ev_q;
  assign cmpa_evt = cmp_ev_q[0];
  assign cmpb_evt = cmp_ev_q[1];

  // R8: the zero strobe appears together with a count of zero
  assert_zero_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (tb_count == '0));
  // R4: in stop-freeze no strobe is raised
  assert_frozen_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl_wr) |=> !(zero_evt || cmpa_evt || cmpb_evt));
endmodule

// File: tb/test_pwm_timebase_aq.sv
module test_pwm_timebase_aq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b, zero_evt, cmpa_evt, cmpb_evt;
  logic [15:0] tb_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pwm_timebase_aq i_pwm_timebase_aq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_evt(zero_evt), .cmpa_evt(cmpa_evt),
    .cmpb_evt(cmpb_evt), .tb_count(tb_count)
  );

  // behavioural reference state
  int m_pc, m_cnt, m_prd, m_sh, m_ctrl;
  int m_cmp[2];
  int m_act[2];
  int m_pwm[2];
  int m_ez;
  int m_ec[2];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int apply_act(int code, int cur);
    case (code)
      1: return 0;
      2: return 1;
      3: return 1 - cur;
      default: return cur;
    endcase
  endfunction

  task automatic model_step();
    int ratio, nx, cw, raw, tk, run, sh_en;
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_prd = 0; m_sh = 0; m_ctrl = 0;
      m_cmp = '{0, 0}; m_act = '{0, 0}; m_pwm = '{0, 0}; m_ez = 0; m_ec = '{0, 0};
      return;
    end
    ratio = (((m_ctrl >> 5) & 7) == 0) ? 1 : 2 * ((m_ctrl >> 5) & 7);
    ratio = ratio * (1 << ((m_ctrl >> 2) & 7));
    run   = ((m_ctrl & 3) == 1);
    sh_en = (m_ctrl >> 8) & 1;
    cw    = wr_en && wr_addr == 4;
    raw   = run && (m_pc == ratio - 1);
    tk    = raw && !cw;
    nx    = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
    m_ez  = tk && nx == 0;
    for (int i = 0; i < 2; i++) begin
      m_ec[i] = tk && nx == m_cmp[i];
      if (m_ec[i])  m_pwm[i] = apply_act((m_act[i] >> 2) & 3, m_pwm[i]);
      else if (m_ez) m_pwm[i] = apply_act(m_act[i] & 3, m_pwm[i]);
    end
    if (!run || raw || (wr_en && (wr_addr == 0 || wr_addr == 4))) m_pc = 0;
    else m_pc++;
    if (wr_en && wr_addr == 1 && !sh_en) m_prd = wr_data;
    else if (tk && m_cnt >= m_prd && sh_en) m_prd = m_sh;
    if (cw) m_cnt = wr_data;
    else if (tk) m_cnt = nx;
    if (wr_en) begin
      case (wr_addr)
        0: m_ctrl = wr_data & 16'h01ff;
        1: m_sh = wr_data;
        2: m_cmp[0] = wr_data;
        3: m_cmp[1] = wr_data;
        5: m_act[0] = wr_data & 15;
        6: m_act[1] = wr_data & 15;
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    if (!rst_n) return;
    chk(tb_count == 16'(m_cnt), "R3 count vs model", tb_count, m_cnt);
    chk(pwm_a == m_pwm[0][0], "R5 pwm_a vs model", pwm_a, m_pwm[0]);
    chk(pwm_b == m_pwm[1][0], "R5 pwm_b vs model", pwm_b, m_pwm[1]);
    chk(zero_evt == m_ez[0], "R8 zero strobe vs model", zero_evt, m_ez);
    chk(cmpa_evt == m_ec[0][0], "R8 cmpa strobe vs model", cmpa_evt, m_ec[0]);
    chk(cmpb_evt == m_ec[1][0], "R8 cmpb strobe vs model", cmpb_evt, m_ec[1]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  function automatic int ctrl(int c, int f, int s);
    return 1 | (c << 2) | (f << 5) | (s << 8);
  endfunction

  task automatic wait_zero();
    for (int n = 0; n < 5000; n++) begin
      if (zero_evt) return;
      cyc();
    end
    chk(0, "R8 zero strobe timeout", 0, 1);
  endtask

  task automatic wait_cnt(int v);
    for (int n = 0; n < 5000; n++) begin
      if (tb_count == 16'(v)) return;
      cyc();
    end
    chk(0, "R3 count value timeout", tb_count, v);
  endtask

  // tracks the largest count until the next zero strobe
  task automatic period_max(output int mx);
    mx = tb_count;
    for (int n = 0; n < 5000; n++) begin
      cyc();
      if (zero_evt) return;
      if (tb_count > mx) mx = tb_count;
    end
    chk(0, "R6 period timeout", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, ha, hb, eb, c0, mx;
    repeat (4) cyc();
    // R1: reset values
    chk(pwm_a == 0 && pwm_b == 0, "R1 outputs low in reset", {pwm_a, pwm_b}, 0);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk(tb_count == 0, "R1 count after reset", tb_count, 0);
    chk({zero_evt, cmpa_evt, cmpb_evt} == 0, "R1 strobes after reset", {zero_evt, cmpa_evt, cmpb_evt}, 0);

    // R2 and R10: ratio 2*6 = 12, period 4, compare B 9 above period
    wr(5, 2 | (3 << 2));
    wr(6, 2 | (3 << 2));
    wr(1, 4);
    wr(2, 2);
    wr(3, 9);
    wr(0, ctrl(1, 3, 0));
    wait_zero();
    n = 0; hb = 0; eb = 0;
    do begin
      if (pwm_b) hb++;
      if (cmpb_evt) eb++;
      cyc(); n++;
    end while (!zero_evt && n < 1000);
    chk(n == 60, "R2 clocks per period", n, 60);
    chk(hb == 60, "R10 out-of-range compare keeps B high", hb, 60);
    chk(eb == 0, "R10 no compare B strobe", eb, 0);

    // R5 and R9: period 9, ratio 1, A set/toggle at 3, B set/low at 0
    wr(0, 0);
    wr(4, 0);
    wr(1, 9);
    wr(2, 3);
    wr(3, 0);
    wr(6, 2 | (1 << 2));
    wr(0, ctrl(0, 0, 0));
    wait_zero();
    ha = 0; hb = 0;
    for (int k = 0; k < 10; k++) begin
      if (pwm_a) ha++;
      if (pwm_b) hb++;
      cyc();
    end
    chk(ha == 3, "R5 A high from zero until compare", ha, 3);
    chk(hb == 0, "R9 compare beats zero on same tick", hb, 0);

    // R4 and R12: stop-freeze holds, address 7 ignored
    wr(0, 0);
    c0 = tb_count;
    wr(7, 16'h1234);
    for (int k = 0; k < 8; k++) begin
      cyc();
      chk(tb_count == 16'(c0), "R4 count frozen", tb_count, c0);
      chk(!zero_evt && !cmpa_evt && !cmpb_evt, "R4 no strobes when frozen", zero_evt, 0);
    end
    chk(tb_count == 16'(c0), "R12 address 7 write ignored", tb_count, c0);

    // R7: counter write restarts prescaler (ratio 4)
    wr(0, ctrl(2, 0, 0));
    wr(4, 0);
    chk(tb_count == 0 && !zero_evt, "R7 counter write loads without event", tb_count, 0);
    n = 0;
    while (tb_count != 1 && n < 50) begin cyc(); n++; end
    chk(n == 4, "R7 full tick after counter write", n, 4);

    // R11: control rewrite restarts prescaler
    cyc(); cyc();
    wr(0, ctrl(2, 0, 0));
    c0 = tb_count; n = 0;
    while (tb_count == 16'(c0) && n < 50) begin cyc(); n++; end
    chk(n == 4, "R11 full tick after control write", n, 4);

    // R6: shadowed period waits for the wrap
    wr(0, ctrl(0, 0, 1));
    wait_zero();
    wait_cnt(2);
    wr(1, 4);
    period_max(mx);
    chk(mx == 9, "R6 shadow period not yet active", mx, 9);
    period_max(mx);
    chk(mx == 4, "R6 shadow period active after wrap", mx, 4);

    // R6: immediate period takes effect at once
    wr(0, ctrl(0, 0, 0));
    wr(1, 9);
    wait_zero();
    wait_cnt(1);
    wr(1, 2);
    period_max(mx);
    chk(mx == 2, "R6 immediate period", mx, 2);
    period_max(mx);
    chk(mx == 2, "R6 immediate period next cycle", mx, 2);

    repeat (20) cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule